// File: doc/BRIEF.md
# DRAM Bank Timing and Activate Window Tracker

This block keeps, for every bank of every rank on one DRAM channel, the row that is currently open and the earliest cycle at which the next activate, precharge or column command may be sent to it. A scheduler outside the block issues commands through three strobes that share one rank, bank and row address. At most one strobe is high per cycle. The block records each command against a free-running cycle count supplied from outside. In return it presents per-bank ready flags that the scheduler uses to pick a legal command.

Beyond the per-bank timing, the block applies two rank-wide rules to activates. The first is a minimum spacing between successive activates, and that spacing is longer when both target the same bank group. The second is a rolling window that admits only a fixed number of activates. Each bank also counts the column accesses made to its open row. Once a set maximum is reached, the bank refuses further column commands and asks for the row to be closed. A query port tells whether a given rank, bank and row would hit the open row.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank reports no open row (all ones on its row field), `act_ok` is all ones, and `pre_ok`, `col_ok`, `close_req` and `row_hit` are all zero.
- R2: Bank `b` is addressed by the flat index `b = rank*BANKS + bank`, and its open row appears at `open_rows[b*ROW_W +: ROW_W]`.
- R3: An activate at cycle t sets the bank's open row to `cmd_row` and clears its access count. `col_ok` stays low before t+T_RCD and `pre_ok` stays low before t+T_RAS.
- R4: A precharge at cycle t sets the row field to all ones, and `act_ok` for that bank stays low before t+T_RP.
- R5: A column command at cycle t holds `col_ok` low before t+T_BURST. It also raises the precharge time to at least t+T_RTP for a read (`col_wr`=0), or to at least t+T_WR+T_BURST for a write. It never lowers the precharge time.
- R6: Within a rank, an activate at cycle t blocks further activates before t+T_RRD. When the next target is in the same bank group, the block lasts until t+T_RRD_L. A bank's group is bank/(BANKS/GROUPS).
- R7: Within a rank, once ACT_LIMIT activates have been issued, a further activate is allowed only from T_XAW cycles after the oldest of the last ACT_LIMIT activates.
- R8: The spacing and window rules of one rank are not affected by activates to another rank.
- R9: After MAX_COL column commands to the same open row, that bank drives `col_ok` low and `close_req` high until it is precharged.
- R10: `row_hit` is high exactly when the queried bank has a row open and that row equals `q_row`.
- R11: `act_ok` is high only for a bank with no open row. `pre_ok` and `col_ok` are high only for a bank with an open row. Every ready flag is high exactly when `now` has reached every bound that applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | TIME_W | Free-running cycle count |
| act_vld | input | 1 | Activate command strobe |
| pre_vld | input | 1 | Precharge command strobe |
| col_vld | input | 1 | Column command strobe |
| col_wr | input | 1 | Column command is a write (1) or read (0) |
| cmd_rank | input | RANK_W | Command rank |
| cmd_bank | input | BANK_W | Command bank within the rank |
| cmd_row | input | ROW_W | Row opened by an activate |
| q_rank | input | RANK_W | Query rank |
| q_bank | input | BANK_W | Query bank |
| q_row | input | ROW_W | Query row |
| open_rows | output | NB*ROW_W | Open row of every bank, all ones when closed |
| row_hit | output | 1 | Query matches an open row |
| act_ok | output | NB | Bank may be activated now |
| pre_ok | output | NB | Bank may be precharged now |
| col_ok | output | NB | Bank may take a column command now |
| close_req | output | NB | Bank reached its access limit and must be closed |

## Verification
The rank-wide activate window and the bank-group spacing rule can both hold back the same activate in the same cycle. The flag must then wait for the later of the two bounds. To provoke this, one rank is driven with back-to-back activates as soon as each is allowed, so that the window fills while the spacing bound is still running. The access-limit close request is also made to coincide with column spacing, by hammering a single bank with column commands. In every cycle, all ready flags are compared against a reference model of the rules, so any cycle in which the wrong bound wins is reported.

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int RANKS     = 2,
  parameter int BANKS     = 4,
  parameter int GROUPS    = 2,
  parameter int ROW_W     = 6,
  parameter int TIME_W    = 20,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3,
  parameter int T_RTP     = 2,
  parameter int T_WR      = 4,
  parameter int T_BURST   = 2,
  parameter int T_RRD     = 2,
  parameter int T_RRD_L   = 3,
  parameter int T_XAW     = 12,
  parameter int ACT_LIMIT = 3,
  parameter int MAX_COL   = 3,
  localparam int NB     = RANKS * BANKS,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TIME_W-1:0]     now,
  input  logic                  act_vld,
  input  logic                  pre_vld,
  input  logic                  col_vld,
  input  logic                  col_wr,
  input  logic [RANK_W-1:0]     cmd_rank,
  input  logic [BANK_W-1:0]     cmd_bank,
  input  logic [ROW_W-1:0]      cmd_row,
  input  logic [RANK_W-1:0]     q_rank,
  input  logic [BANK_W-1:0]     q_bank,
  input  logic [ROW_W-1:0]      q_row,
  output logic [NB*ROW_W-1:0]   open_rows,
  output logic                  row_hit,
  output logic [NB-1:0]         act_ok,
  output logic [NB-1:0]         pre_ok,
  output logic [NB-1:0]         col_ok,
  output logic [NB-1:0]         close_req
);
  localparam int BPG   = BANKS / GROUPS;
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int CNT_W = $clog2(MAX_COL + 1);
  localparam int HC_W  = $clog2(ACT_LIMIT + 1);
  localparam logic [ROW_W-1:0] NONE = '1;

  logic [IDX_W-1:0] cidx, qidx;
  logic [GRP_W-1:0] cgrp;
  logic [ROW_W-1:0] q_open;

  assign cidx   = IDX_W'(cmd_rank) * IDX_W'(BANKS) + IDX_W'(cmd_bank);
  assign qidx   = IDX_W'(q_rank) * IDX_W'(BANKS) + IDX_W'(q_bank);
  assign cgrp   = GRP_W'(32'(cmd_bank) / BPG);
  assign q_open = open_rows[qidx*ROW_W +: ROW_W];
  assign row_hit = (q_open != NONE) && (q_open == q_row);

  for (genvar r = 0; r < RANKS; r++) begin : rk
    logic [TIME_W-1:0] hist [ACT_LIMIT];
    logic [HC_W-1:0]   hcnt;
    logic [TIME_W-1:0] last_t;
    logic [GRP_W-1:0]  lgrp;
    logic              have;
    logic              mine;
    logic              win_ok;

    assign mine   = act_vld && (cmd_rank == RANK_W'(r));
    assign win_ok = (hcnt < HC_W'(ACT_LIMIT)) ||
                    (now >= hist[ACT_LIMIT-1] + TIME_W'(T_XAW));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < ACT_LIMIT; k++) hist[k] <= '0;
        hcnt   <= '0;
        last_t <= '0;
        lgrp   <= '0;
        have   <= 1'b0;
      end else if (mine) begin
        hist[0] <= now;
        for (int k = 1; k < ACT_LIMIT; k++) hist[k] <= hist[k-1];
        if (hcnt < HC_W'(ACT_LIMIT)) hcnt <= hcnt + 1'b1;
        last_t <= now;
        lgrp   <= cgrp;
        have   <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : bk
    localparam int R = b / BANKS;
    localparam int G = (b % BANKS) / BPG;
    logic [ROW_W-1:0]  orow;
    logic [TIME_W-1:0] col_at, pre_at, act_at, col_pre, gap_t;
    logic [CNT_W-1:0]  cnt;
    logic              sel, is_open;

    assign sel     = (cidx == IDX_W'(b));
    assign is_open = (orow != NONE);
    assign col_pre = col_wr ? now + TIME_W'(T_WR + T_BURST) : now + TIME_W'(T_RTP);
    assign gap_t   = rk[R].last_t + ((rk[R].lgrp == GRP_W'(G)) ? TIME_W'(T_RRD_L)
                                                                : TIME_W'(T_RRD));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        orow   <= NONE;
        col_at <= '0;
        pre_at <= '0;
        act_at <= '0;
        cnt    <= '0;
      end else if (sel) begin
        if (act_vld) begin
          orow   <= cmd_row;
          col_at <= now + TIME_W'(T_RCD);
          pre_at <= now + TIME_W'(T_RAS);
          cnt    <= '0;
        end else if (pre_vld) begin
          orow   <= NONE;
          act_at <= now + TIME_W'(T_RP);
        end else if (col_vld) begin
          col_at <= now + TIME_W'(T_BURST);
          if (col_pre > pre_at) pre_at <= col_pre;
          if (cnt < CNT_W'(MAX_COL)) cnt <= cnt + 1'b1;
        end
      end
    end

    assign open_rows[b*ROW_W +: ROW_W] = orow;
    assign act_ok[b]    = !is_open && (now >= act_at) && rk[R].win_ok &&
                          (!rk[R].have || (now >= gap_t));
    assign pre_ok[b]    = is_open && (now >= pre_at);
    assign col_ok[b]    = is_open && (now >= col_at) && (cnt < CNT_W'(MAX_COL));
    assign close_req[b] = is_open && (cnt >= CNT_W'(MAX_COL));
  end
endmodule

// File: rtl/dram_bank_tracker_chk.sv
module dram_bank_tracker_chk #(
  parameter int RANKS   = 2,
  parameter int BANKS   = 4,
  parameter int ROW_W   = 6,
  parameter int T_RCD   = 3,
  parameter int T_BURST = 2,
  localparam int NB     = RANKS * BANKS,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                act_vld,
  input logic                pre_vld,
  input logic                col_vld,
  input logic [RANK_W-1:0]   cmd_rank,
  input logic [BANK_W-1:0]   cmd_bank,
  input logic [ROW_W-1:0]    cmd_row,
  input logic [NB*ROW_W-1:0] open_rows,
  input logic [NB-1:0]       act_ok,
  input logic [NB-1:0]       col_ok,
  input logic [NB-1:0]       close_req
);
  logic [IDX_W-1:0] cidx;
  assign cidx = IDX_W'(cmd_rank) * IDX_W'(BANKS) + IDX_W'(cmd_bank);

  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> open_rows[$past(cidx)*ROW_W +: ROW_W] == $past(cmd_row));

  a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld |=> open_rows[$past(cidx)*ROW_W +: ROW_W] == {ROW_W{1'b1}});

  a_r11_open_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> !act_ok[$past(cidx)]);

  a_r3_rcd_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && (T_RCD > 1)) |=> !col_ok[$past(cidx)]);

  a_r5_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && (T_BURST > 1)) |=> !col_ok[$past(cidx)]);

  a_r9_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (close_req & col_ok) == '0);
endmodule

bind dram_bank_tracker dram_bank_tracker_chk #(
  .RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_BURST(T_BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .pre_vld(pre_vld), .col_vld(col_vld),
  .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
  .open_rows(open_rows), .act_ok(act_ok), .col_ok(col_ok), .close_req(close_req)
);

// File: tb/dram_bank_tracker_tb_top.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb_top;
  localparam int RANKS = 2, BANKS = 4, GROUPS = 2, ROW_W = 6, TIME_W = 20;
  localparam int T_RCD = 3, T_RAS = 8, T_RP = 3, T_RTP = 2, T_WR = 4, T_BURST = 2;
  localparam int T_RRD = 2, T_RRD_L = 3, T_XAW = 12, ACT_LIMIT = 3, MAX_COL = 3;
  localparam int NB = RANKS * BANKS;
  localparam int NONE = (1 << ROW_W) - 1;

  logic clk = 0, rst_n = 0;
  logic [TIME_W-1:0] now = '0;
  logic act_vld = 0, pre_vld = 0, col_vld = 0, col_wr = 0;
  logic [0:0] cmd_rank = '0, q_rank = '0;
  logic [1:0] cmd_bank = '0, q_bank = '0;
  logic [ROW_W-1:0] cmd_row = '0, q_row = '0;
  logic [NB*ROW_W-1:0] open_rows;
  logic row_hit;
  logic [NB-1:0] act_ok, pre_ok, col_ok, close_req;

  always #2 clk = ~clk;

  dram_bank_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .now(now), .act_vld(act_vld), .pre_vld(pre_vld),
    .col_vld(col_vld), .col_wr(col_wr), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
    .open_rows(open_rows), .row_hit(row_hit), .act_ok(act_ok), .pre_ok(pre_ok),
    .col_ok(col_ok), .close_req(close_req));

  int nchk = 0, nfail = 0, t = 0;
  int m_row[NB], m_col_at[NB], m_pre_at[NB], m_act_at[NB], m_cnt[NB];
  int m_hist[RANKS][ACT_LIMIT], m_hcnt[RANKS], m_last[RANKS], m_lgrp[RANKS];
  bit m_have[RANKS];

  function automatic int grp_of(int b); return (b % BANKS) / (BANKS / GROUPS); endfunction

  function automatic bit e_act(int b, int tt);
    int r = b / BANKS;
    if (m_row[b] != NONE || tt < m_act_at[b]) return 0;
    if (m_hcnt[r] >= ACT_LIMIT && tt < m_hist[r][ACT_LIMIT-1] + T_XAW) return 0;
    if (m_have[r] && tt < m_last[r] + ((grp_of(b) == m_lgrp[r]) ? T_RRD_L : T_RRD)) return 0;
    return 1;
  endfunction
  function automatic bit e_pre(int b, int tt); return m_row[b] != NONE && tt >= m_pre_at[b]; endfunction
  function automatic bit e_col(int b, int tt);
    return m_row[b] != NONE && tt >= m_col_at[b] && m_cnt[b] < MAX_COL;
  endfunction
  function automatic bit e_close(int b); return m_row[b] != NONE && m_cnt[b] >= MAX_COL; endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s at t=%0d: actual %0h expected %0h", req, what, t, act, exp);
    end
  endtask

  task automatic check_all();
    logic [NB-1:0] ea, ep, ec, ex;
    logic [NB*ROW_W-1:0] er;
    int qb = int'(q_rank) * BANKS + int'(q_bank);
    bit eh = (m_row[qb] != NONE) && (m_row[qb] == int'(q_row));
    for (int b = 0; b < NB; b++) begin
      ea[b] = e_act(b, t); ep[b] = e_pre(b, t); ec[b] = e_col(b, t); ex[b] = e_close(b);
      er[b*ROW_W +: ROW_W] = ROW_W'(m_row[b]);
    end
    chk(open_rows === er, "R2/R3/R4", "open_rows", open_rows, er);
    chk(act_ok === ea, "R6/R7/R8/R11", "act_ok", act_ok, ea);
    chk(pre_ok === ep, "R3/R5/R11", "pre_ok", pre_ok, ep);
    chk(col_ok === ec, "R3/R5/R9", "col_ok", col_ok, ec);
    chk(close_req === ex, "R9", "close_req", close_req, ex);
    chk(row_hit === eh, "R10", "row_hit", row_hit, eh);
  endtask

  task automatic model_apply(int kind, int b, int row, bit wr);
    int r = b / BANKS;
    if (kind == 1) begin
      m_row[b] = row; m_col_at[b] = t + T_RCD; m_pre_at[b] = t + T_RAS; m_cnt[b] = 0;
      for (int k = ACT_LIMIT - 1; k > 0; k--) m_hist[r][k] = m_hist[r][k-1];
      m_hist[r][0] = t;
      if (m_hcnt[r] < ACT_LIMIT) m_hcnt[r]++;
      m_last[r] = t; m_lgrp[r] = grp_of(b); m_have[r] = 1;
    end else if (kind == 2) begin
      m_row[b] = NONE; m_act_at[b] = t + T_RP;
    end else if (kind == 3) begin
      int nx = wr ? t + T_WR + T_BURST : t + T_RTP;
      m_cnt[b]++; m_col_at[b] = t + T_BURST;
      if (nx > m_pre_at[b]) m_pre_at[b] = nx;
    end
  endtask

  // mode 0: random, 1: greedy activates on rank 0, 2: column hammer on bank 5
  task automatic step(int mode);
    int kind = 0, b = 0, row = 0, qb;
    bit wr = 0;
    @(negedge clk);
    now = TIME_W'(t);
    row = $urandom % NONE;
    wr = $urandom % 2;
    if (mode == 1) begin
      for (int i = BANKS - 1; i >= 0; i--) if (e_act(i, t)) begin kind = 1; b = i; end
      if (kind == 0) for (int i = 0; i < BANKS; i++) if (e_pre(i, t)) begin kind = 2; b = i; end
    end else if (mode == 2) begin
      b = 5;
      if (e_act(b, t)) kind = 1;
      else if (e_col(b, t)) kind = 3;
      else if (e_close(b) && e_pre(b, t)) kind = 2;
    end else begin
      int k = $urandom % 4;
      b = $urandom % NB;
      if (k == 0 && e_act(b, t)) kind = 1;
      else if ((k == 1 || e_close(b)) && e_pre(b, t)) kind = 2;
      else if (k >= 2 && e_col(b, t)) kind = 3;
    end
    act_vld = (kind == 1); pre_vld = (kind == 2); col_vld = (kind == 3); col_wr = wr;
    cmd_rank = 1'(b / BANKS); cmd_bank = 2'(b % BANKS); cmd_row = ROW_W'(row);
    qb = $urandom % NB;
    q_rank = 1'(qb / BANKS); q_bank = 2'(qb % BANKS);
    q_row = ($urandom % 3 != 0) ? ROW_W'(m_row[qb]) : ROW_W'($urandom);
    #1;
    check_all();
    model_apply(kind, b, row, wr);
    t++;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin
      m_row[b] = NONE; m_col_at[b] = 0; m_pre_at[b] = 0; m_act_at[b] = 0; m_cnt[b] = 0;
    end
    for (int r = 0; r < RANKS; r++) begin
      for (int k = 0; k < ACT_LIMIT; k++) m_hist[r][k] = 0;
      m_hcnt[r] = 0; m_last[r] = 0; m_lgrp[r] = 0; m_have[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1: reset state
    chk(act_ok === '1 && pre_ok === '0 && col_ok === '0 && close_req === '0,
        "R1", "flags after reset", {act_ok, pre_ok, col_ok, close_req}, {{NB{1'b1}}, {3*NB{1'b0}}});
    chk(open_rows === '1, "R1", "open_rows after reset", open_rows, {NB*ROW_W{1'b1}});
    chk(row_hit === 1'b0, "R1", "row_hit after reset", row_hit, 0);
    // R7 with R6: window and group spacing collide on rank 0
    for (int i = 0; i < 400; i++) step(1);
    // R9 with R5: access limit and column spacing on one bank
    for (int i = 0; i < 300; i++) step(2);
    for (int i = 0; i < 8000; i++) step(0);
    act_vld = 0; pre_vld = 0; col_vld = 0;
    finish_run();
  end
endmodule